// File: doc/BRIEF.md
# Contiguous memory span calculator

The block works out how much memory can be used as one unbroken window that starts at the lowest configured address. Two memory controllers each supply up to two chip-region descriptors. Each controller also supplies an enable bit and a count of extra chips. A descriptor is a 32-bit word. Its top byte gives the region base, with the low 24 address bits zero. The next byte down is an address mask, and its inverse gives the low bits of the region's last address.

A one-cycle start pulse captures the descriptors. Slots that are not populated are filled with all ones. The four slots then pass through a fixed five-step compare-exchange sorting network, one step per clock. In the final cycle the block sums region lengths upward from the lowest slot. It adds a region only while that region begins right after the end of the one before it. The total appears on the length output together with a one-cycle valid pulse, and it holds until the next result.

Top module: `mem_span_calc`

## Requirements
- R1: After reset, `span_valid` is 0 and `span_len` is 0.
- R2: The slots are captured at the clock edge that accepts start. Slot 0 takes `desc0` when `ctl0_en` is 1. Slot 1 takes `desc1` only when `ctl0_en` is 1 and `ctl0_extra` (the 4-bit extra-chip count field) is nonzero. Slots 2 and 3 follow the same rule with `ctl1_en`, `ctl1_extra`, `desc2` and `desc3`. Every other slot holds 0xFFFFFFFF.
- R3: For a descriptor d, the region base is d with bits [23:0] cleared. The region top is the base ORed with the inverse of (d[23:16] shifted to bits [31:24]), taken over all 32 bits. The region length is top − base + 1, modulo 2^32. Bits [15:0] of d do not affect the length.
- R4: The slots are sorted in ascending unsigned order of the full 32-bit word. The network compare-exchanges slot pairs (0,2), (1,3), (0,1), (2,3) and then (1,2), and each exchange leaves the smaller value in the lower slot.
- R5: When the lowest sorted slot is 0xFFFFFFFF, the reported length is 0.
- R6: The length is the lowest slot's region length, plus the length of each following slot in turn while its base equals the previous slot's top + 1. Accumulation stops at the first slot whose base does not match, even if later slots would join up again.
- R7: `span_len` and `span_valid` update at the sixth clock edge after the edge that accepts start. `span_valid` is high for exactly one cycle, and `span_len` holds its value until the next result.
- R8: A start pulse is accepted only when the block is idle. Start pulses and descriptor changes while a calculation is in progress have no effect on that result and produce no extra result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (accepted when idle) |
| ctl0_en | input | 1 | First controller enabled |
| ctl0_extra | input | 4 | First controller extra-chip count |
| ctl1_en | input | 1 | Second controller enabled |
| ctl1_extra | input | 4 | Second controller extra-chip count |
| desc0 | input | 32 | First controller, chip 0 descriptor |
| desc1 | input | 32 | First controller, chip 1 descriptor |
| desc2 | input | 32 | Second controller, chip 0 descriptor |
| desc3 | input | 32 | Second controller, chip 1 descriptor |
| span_len | output | 32 | Length of the contiguous window at the lowest base |
| span_valid | output | 1 | One-cycle pulse when span_len is new |

## Verification
The bench builds the block with the package defaults: 32-bit descriptors, four slots, a five-step network, and base and mask bytes at bits [31:24] and [23:16]. Full-width descriptors let the bench place a region just below the top of the address space. There, an unused all-ones slot starts exactly one past the region's end and adds to the total. The same widths let it place a base byte that is not aligned to the mask, and a descriptor with nonzero low bits. Four slots in reversed or interleaved order exercise every exchange of the network. Vectors with a gap in the address chain show that accumulation stops at the first break.

// File: rtl/mspan_pkg.sv
package mspan_pkg;
    localparam int DESC_W         = 32;
    localparam int NUM_CTRL       = 2;
    localparam int SLOTS_PER_CTRL = 2;
    localparam int NUM_SLOTS      = NUM_CTRL * SLOTS_PER_CTRL;
    localparam int NUM_STAGES     = 5;
    localparam int STAGE_W        = $clog2(NUM_STAGES);
    localparam int SLOT_IDX_W     = $clog2(NUM_SLOTS);
    localparam int CNT_W          = 4;
    localparam int BASE_LSB       = 24;
    localparam int MASK_LSB       = 16;
    localparam int MASK_W         = 8;

    typedef logic [DESC_W-1:0]     desc_t;
    typedef desc_t [NUM_SLOTS-1:0] slot_vec_t;
    typedef logic [SLOT_IDX_W-1:0] slot_idx_t;
    typedef enum logic [1:0] {ST_IDLE, ST_SORT, ST_DONE} state_e;

    localparam desc_t UNUSED_SLOT = '1;
    localparam desc_t BASE_MASK   = desc_t'({DESC_W{1'b1}}) << BASE_LSB;
    localparam desc_t FIELD_MASK  = desc_t'((1 << MASK_W) - 1) << MASK_LSB;

    function automatic desc_t region_base(input desc_t d);
        return d & BASE_MASK;
    endfunction

    function automatic desc_t region_top(input desc_t d);
        return region_base(d) | ~((d & FIELD_MASK) << (BASE_LSB - MASK_LSB));
    endfunction

    function automatic desc_t region_len(input desc_t d);
        return region_top(d) - region_base(d) + desc_t'(1);
    endfunction

    // Compare-exchange pairs per network step, executed in step order.
    function automatic slot_idx_t pair_lo(input logic [STAGE_W-1:0] s);
        case (s)
            3'd0:    return slot_idx_t'(0);
            3'd1:    return slot_idx_t'(1);
            3'd2:    return slot_idx_t'(0);
            3'd3:    return slot_idx_t'(2);
            default: return slot_idx_t'(1);
        endcase
    endfunction

    function automatic slot_idx_t pair_hi(input logic [STAGE_W-1:0] s);
        case (s)
            3'd0:    return slot_idx_t'(2);
            3'd1:    return slot_idx_t'(3);
            3'd2:    return slot_idx_t'(1);
            3'd3:    return slot_idx_t'(3);
            default: return slot_idx_t'(2);
        endcase
    endfunction
endpackage

// File: rtl/mspan_cmpswap.sv
module mspan_cmpswap
    import mspan_pkg::*;
(
    input  slot_vec_t            slots_in,
    input  logic [STAGE_W-1:0]   stage,
    output slot_vec_t            slots_out
);
    slot_idx_t lo_idx;
    slot_idx_t hi_idx;

    always_comb begin
        lo_idx    = pair_lo(stage);
        hi_idx    = pair_hi(stage);
        slots_out = slots_in;
        if (slots_in[hi_idx] < slots_in[lo_idx]) begin
            slots_out[lo_idx] = slots_in[hi_idx];
            slots_out[hi_idx] = slots_in[lo_idx];
        end
    end
endmodule

// File: rtl/mspan_accum.sv
module mspan_accum
    import mspan_pkg::*;
(
    input  slot_vec_t slots,
    output desc_t     total
);
    desc_t base_w [NUM_SLOTS];
    desc_t top_w  [NUM_SLOTS];
    desc_t len_w  [NUM_SLOTS];
    desc_t part_w [NUM_SLOTS];
    logic  link_w [NUM_SLOTS];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_region
        assign base_w[i] = region_base(slots[i]);
        assign top_w[i]  = region_top(slots[i]);
        assign len_w[i]  = region_len(slots[i]);
        if (i == 0) begin : g_first
            assign link_w[i] = 1'b1;
            assign part_w[i] = len_w[i];
        end else begin : g_next
            assign link_w[i] = link_w[i-1] && (base_w[i] == top_w[i-1] + desc_t'(1));
            assign part_w[i] = part_w[i-1] + (link_w[i] ? len_w[i] : desc_t'(0));
        end
    end

    assign total = (slots[0] == UNUSED_SLOT) ? desc_t'(0) : part_w[NUM_SLOTS-1];
endmodule

// File: rtl/mem_span_calc.sv
module mem_span_calc
    import mspan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ctl0_en,
    input  logic [CNT_W-1:0]  ctl0_extra,
    input  logic              ctl1_en,
    input  logic [CNT_W-1:0]  ctl1_extra,
    input  logic [DESC_W-1:0] desc0,
    input  logic [DESC_W-1:0] desc1,
    input  logic [DESC_W-1:0] desc2,
    input  logic [DESC_W-1:0] desc3,
    output logic [DESC_W-1:0] span_len,
    output logic              span_valid
);
    typedef struct packed {
        state_e               state;
        logic [STAGE_W-1:0]   stage;
        slot_vec_t            slots;
        desc_t                len;
        logic                 valid;
    } regs_t;

    regs_t q, d;

    desc_t              desc_in [NUM_SLOTS];
    logic               ctl_en  [NUM_CTRL];
    logic [CNT_W-1:0]   ctl_cnt [NUM_CTRL];
    slot_vec_t          loaded;
    slot_vec_t          swapped;
    slot_vec_t          cur_slots;
    desc_t              total;
    logic               in_idle;
    logic               in_done;

    assign desc_in[0] = desc0;
    assign desc_in[1] = desc1;
    assign desc_in[2] = desc2;
    assign desc_in[3] = desc3;
    assign ctl_en[0]  = ctl0_en;
    assign ctl_en[1]  = ctl1_en;
    assign ctl_cnt[0] = ctl0_extra;
    assign ctl_cnt[1] = ctl1_extra;

    for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
        localparam int FIRST = c * SLOTS_PER_CTRL;
        assign loaded[FIRST]   = ctl_en[c] ? desc_in[FIRST] : UNUSED_SLOT;
        assign loaded[FIRST+1] = (ctl_en[c] && (ctl_cnt[c] != '0))
                                 ? desc_in[FIRST+1] : UNUSED_SLOT;
    end

    assign cur_slots = q.slots;
    assign in_idle   = (q.state == ST_IDLE);
    assign in_done   = (q.state == ST_DONE);

    mspan_cmpswap u_cmpswap (
        .slots_in  (cur_slots),
        .stage     (q.stage),
        .slots_out (swapped)
    );

    mspan_accum u_accum (
        .slots (cur_slots),
        .total (total)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start && in_idle) begin
                    d.slots = loaded;
                    d.stage = '0;
                    d.state = ST_SORT;
                end
            end
            ST_SORT: begin
                d.slots = swapped;
                if (q.stage == STAGE_W'(NUM_STAGES - 1)) begin
                    d.state = ST_DONE;
                end else begin
                    d.stage = q.stage + STAGE_W'(1);
                end
            end
            ST_DONE: begin
                if (in_done) begin
                    d.len   = total;
                    d.valid = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.stage <= '0;
            q.slots <= {NUM_SLOTS{UNUSED_SLOT}};
            q.len   <= '0;
            q.valid <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign span_len   = q.len;
    assign span_valid = q.valid;
endmodule

// File: rtl/mspan_checker.sv
module mspan_checker
    import mspan_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      start,
    input logic      ctl0_en,
    input logic      ctl1_en,
    input logic      in_idle,
    input logic      in_done,
    input slot_vec_t cur_slots,
    input desc_t     span_len,
    input logic      span_valid
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        span_valid |=> !span_valid); // R7

    AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        span_valid |-> $past(start && in_idle, 7)); // R8

    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(span_valid) |-> $stable(span_len)); // R7

    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (span_valid && $past(start && in_idle && !ctl0_en && !ctl1_en, 7))
        |-> (span_len == '0)); // R5

    AST_SORTED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        in_done |-> ((cur_slots[0] <= cur_slots[1]) && (cur_slots[1] <= cur_slots[2])
                     && (cur_slots[2] <= cur_slots[3]))); // R4
endmodule

bind mem_span_calc mspan_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ctl0_en    (ctl0_en),
    .ctl1_en    (ctl1_en),
    .in_idle    (in_idle),
    .in_done    (in_done),
    .cur_slots  (cur_slots),
    .span_len   (span_len),
    .span_valid (span_valid)
);

// File: tb/mem_span_calc_tb_top.sv
module mem_span_calc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ctl0_en = 1'b0;
    logic [3:0]  ctl0_extra = '0;
    logic        ctl1_en = 1'b0;
    logic [3:0]  ctl1_extra = '0;
    logic [31:0] desc0 = '0, desc1 = '0, desc2 = '0, desc3 = '0;
    logic [31:0] span_len;
    logic        span_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mem_span_calc dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ctl0_en(ctl0_en), .ctl0_extra(ctl0_extra),
        .ctl1_en(ctl1_en), .ctl1_extra(ctl1_extra),
        .desc0(desc0), .desc1(desc1), .desc2(desc2), .desc3(desc3),
        .span_len(span_len), .span_valid(span_valid)
    );

    typedef struct packed {
        logic        en0;
        logic [3:0]  cnt0;
        logic        en1;
        logic [3:0]  cnt1;
        logic [31:0] d0;
        logic [31:0] d1;
        logic [31:0] d2;
        logic [31:0] d3;
        logic [31:0] exp_len;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd1, 1'b0, 4'd0, 32'h20F00000, 32'h30F00000, 32'h0, 32'h0, 32'h20000000},
        '{1'b1, 4'd1, 1'b1, 4'd1, 32'h40F80000, 32'h20F00000, 32'h48F80000, 32'h30F00000, 32'h30000000},
        '{1'b1, 4'd1, 1'b1, 4'd1, 32'h20F00000, 32'h38F80000, 32'h40F00000, 32'h48F00000, 32'h10000000},
        '{1'b1, 4'd0, 1'b1, 4'd1, 32'h20F00000, 32'h30F00000, 32'h40F00000, 32'h50F00000, 32'h10000000},
        '{1'b0, 4'd15, 1'b1, 4'd0, 32'h10F00000, 32'h00F00000, 32'h60E00000, 32'h70F00000, 32'h20000000},
        '{1'b0, 4'd3, 1'b0, 4'd2, 32'h20F00000, 32'h30F00000, 32'h40F00000, 32'h50F00000, 32'h00000000},
        '{1'b1, 4'd0, 1'b0, 4'd0, 32'h28F00000, 32'h0, 32'h0, 32'h0, 32'h08000000},
        '{1'b1, 4'd0, 1'b0, 4'd0, 32'h20F0ABCD, 32'h0, 32'h0, 32'h0, 32'h10000000},
        '{1'b1, 4'd1, 1'b0, 4'd0, 32'h20F00000, 32'h20F00000, 32'h0, 32'h0, 32'h10000000},
        '{1'b1, 4'd0, 1'b0, 4'd0, 32'hFEFF0000, 32'h0, 32'h0, 32'h0, 32'h02000000},
        '{1'b0, 4'd0, 1'b1, 4'd1, 32'h0, 32'h0, 32'h00F00000, 32'h10F00000, 32'h20000000}
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 2, 8, 9: return "R6";
            1, 10:      return "R4";
            3, 4:       return "R2";
            5:          return "R5";
            default:    return "R3";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        ctl0_en = v.en0; ctl0_extra = v.cnt0;
        ctl1_en = v.en1; ctl1_extra = v.cnt1;
        desc0 = v.d0; desc1 = v.d1; desc2 = v.d2; desc3 = v.d3;
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        int waited;
        @(negedge clk);
        apply(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 1;
        while (!span_valid && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        check(span_len == v.exp_len, tag, span_len, v.exp_len);
        check(waited == 7, "R7 latency", 32'(waited), 32'd7);
        @(negedge clk);
        check(span_valid == 1'b0, "R7 pulse", 32'(span_valid), 32'd0);
        check(span_len == v.exp_len, "R7 hold", span_len, v.exp_len);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
            report();
        end
    end

    initial begin
        int waited;
        bit extra_seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(span_valid == 1'b0, "R1 valid", 32'(span_valid), 32'd0);
        check(span_len == 32'd0, "R1 len", span_len, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(span_valid == 1'b0, "R1 idle", 32'(span_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i], tag_of(i));
        end

        // R8: start and input changes while busy are ignored
        @(negedge clk);
        apply(VEC[1]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        apply(VEC[5]);
        waited = 1;
        @(negedge clk);
        start = 1'b1;
        waited++;
        @(negedge clk);
        start = 1'b0;
        waited++;
        while (!span_valid && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        check(span_len == 32'h30000000, "R8 captured", span_len, 32'h30000000);
        check(waited == 7, "R8 latency", 32'(waited), 32'd7);
        extra_seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (span_valid) extra_seen = 1'b1;
        end
        check(extra_seen == 1'b0, "R8 no extra result", 32'(extra_seen), 32'd0);
        check(span_len == 32'h30000000, "R8 hold", span_len, 32'h30000000);

        // R2: back-to-back run after the busy window uses new inputs
        run_vec(VEC[3], "R2");

        finished = 1'b1;
        report();
    end
endmodule